// File: doc/BRIEF.md
# Strobe-Qualified Bus Write Capture

This block is the front end of a flash-style memory that faces an asynchronous parallel bus. A fast system clock samples it. Three active-low strobes drive it: chip select, write strobe and output enable. It also takes an address bus and a data bus. Each strobe passes through a two-flop synchronizer and then a glitch filter. The filter counts consecutive samples and takes a new level only after it has held for `GLITCH_CYC` samples. This models a filter of a few nanoseconds that rejects noise pulses.

A write window is open while the filtered chip select and write strobe are both low and output enable is high. The address is taken at the moment both select strobes become active, which is the later of their two falling edges. The data is taken when the first of the two strobes returns high. The address and data buses pass through a delay line as deep as the strobe path, so each value comes from the same sample instant as the strobe edge that selects it. A completed window appears as a one-cycle `wr_valid` pulse that carries the captured address and data to a command controller downstream. If output enable falls while the window is open, the cycle is abandoned. The block also decodes a read enable and a standby indication from the filtered strobes.

Top module: `bus_write_capture`

## Requirements
- R1: A write window opens only when filtered chip select and write strobe both become low while output enable is high. If output enable is low at that moment, no write is produced for that select period, even if output enable later rises.
- R2: `wr_addr` carries the address bus value at the first sample in which both chip select and write strobe are low. Later address changes inside the window have no effect.
- R3: `wr_data` carries the data bus value at the first sample in which chip select or write strobe is high again. This holds whichever of the two strobes rises first.
- R4: A strobe level that lasts fewer than `GLITCH_CYC` consecutive samples is ignored: it neither opens nor closes a write. A level of exactly `GLITCH_CYC` samples is accepted.
- R5: Each completed window gives exactly one `wr_valid` pulse, one cycle wide. It appears on the (`SYNC_STAGES`+`GLITCH_CYC`+1)-th rising clock edge after the raw strobe edge that ends the window (6 with the defaults).
- R6: If output enable goes low (filtered) while a window is open, the cycle is abandoned and no `wr_valid` pulse is produced for it.
- R7: `rd_en` is high exactly when the filtered chip select is low, output enable is low and write strobe is high. It follows a raw strobe change on the (`SYNC_STAGES`+`GLITCH_CYC`)-th rising edge (5 with the defaults).
- R8: `standby` is high exactly when the filtered chip select is high, and `rd_en` is low then.
- R9: Driving `rst_n` low drops any partly captured cycle. `wr_valid` stays low during reset. After reset, all filtered strobes are high, so `standby`=1, `rd_en`=0 and `wr_valid`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_cs_n | input | 1 | Raw chip select strobe, active low |
| bus_wr_n | input | 1 | Raw write strobe, active low |
| bus_oe_n | input | 1 | Raw output enable strobe, active low |
| bus_addr | input | ADDR_W | Raw address bus |
| bus_data | input | DATA_W | Raw data bus (write direction) |
| wr_valid | output | 1 | One-cycle pulse per completed write window |
| wr_addr | output | ADDR_W | Captured write address, valid with `wr_valid` |
| wr_data | output | DATA_W | Captured write data, valid with `wr_valid` |
| rd_en | output | 1 | Decoded read output enable |
| standby | output | 1 | Chip not selected (filtered chip select high) |

## Verification
A raw strobe change reaches `rd_en` and `standby` on the fifth rising edge after it, and a window-closing strobe edge produces `wr_valid` on the sixth. The bench drives every input on the falling clock edge and counts falling edges until the output moves, so each latency is checked as an exact number. It samples there, never at an active edge. For stimuli that must not produce a write (short pulses, an abort by output enable, a blocked start, reset in mid-cycle), the bench waits fifteen cycles, which is well past the six-edge latency. It then compares a pulse counter that a falling-edge monitor keeps.

// File: rtl/wbus_pkg.sv
`timescale 1ns/1ps
package wbus_pkg;

  // Index of each strobe inside the filtered strobe vector
  localparam int STB_CS = 0;
  localparam int STB_WR = 1;
  localparam int STB_OE = 2;
  localparam int NUM_STROBES = 3;

  typedef enum logic [1:0] {
    WS_IDLE    = 2'd0,
    WS_ACTIVE  = 2'd1,
    WS_BLOCKED = 2'd2
  } wstate_e;

  // Samples from a raw strobe edge until the filtered level moves,
  // also the depth the bus delay line needs to stay aligned.
  function automatic int capture_latency(input int sync_stages, input int glitch_cyc);
    return sync_stages + glitch_cyc;
  endfunction

  // Width of the consecutive-sample counter of a filter
  function automatic int filter_cnt_width(input int glitch_cyc);
    return (glitch_cyc < 2) ? 1 : $clog2(glitch_cyc);
  endfunction

  // Levels are raw pin levels: 1 = high (inactive for these strobes)
  function automatic logic select_pair_low(input logic cs_lvl, input logic wr_lvl);
    return !cs_lvl && !wr_lvl;
  endfunction

  function automatic logic read_window(input logic cs_lvl, input logic wr_lvl,
                                       input logic oe_lvl);
    return !cs_lvl && !oe_lvl && wr_lvl;
  endfunction

endpackage

// File: rtl/strobe_deglitch.sv
`timescale 1ns/1ps
module strobe_deglitch #(
  parameter int SYNC_STAGES = 2,
  parameter int GLITCH_CYC  = 3,
  parameter logic RST_LEVEL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw,
  output logic level
);
  import wbus_pkg::*;

  localparam int CNT_W = filter_cnt_width(GLITCH_CYC);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(GLITCH_CYC - 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   sample;
  logic [CNT_W-1:0]       cnt_q;
  logic                   differs;
  logic                   accept_evt;

  // Synchronizer chain, SYNC_STAGES >= 2
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= {SYNC_STAGES{RST_LEVEL}};
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], raw};
    end
  end

  assign sample     = sync_q[SYNC_STAGES-1];
  assign differs    = (sample != level);
  assign accept_evt = differs && (cnt_q == CNT_LAST);

  // Consecutive-sample filter: a new level must persist GLITCH_CYC samples
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level <= RST_LEVEL;
      cnt_q <= '0;
    end else if (accept_evt) begin
      level <= sample;
      cnt_q <= '0;
    end else if (differs) begin
      cnt_q <= cnt_q + 1'b1;
    end else begin
      cnt_q <= '0;
    end
  end

  // R4: the filtered level only moves after the counter has run out
  assert_level_needs_full_count_R4: assert property (
    @(posedge clk) disable iff (!rst_n)
    (level != $past(level)) |-> (($past(cnt_q) == CNT_LAST) && ($past(sample) == level))
  );

endmodule

// File: rtl/bus_delay_line.sv
`timescale 1ns/1ps
module bus_delay_line #(
  parameter int WIDTH = 36,
  parameter int DEPTH = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] stage_q [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) begin
        stage_q[i] <= '0;
      end
    end else begin
      stage_q[0] <= din;
      for (int i = 1; i < DEPTH; i++) begin
        stage_q[i] <= stage_q[i-1];
      end
    end
  end

  assign dout = stage_q[DEPTH-1];

endmodule

// File: rtl/write_cycle_ctrl.sv
`timescale 1ns/1ps
module write_cycle_ctrl #(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_lvl,
  input  logic              wr_lvl,
  input  logic              oe_lvl,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [DATA_W-1:0] data_in,
  output logic              wr_valid,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data
);
  import wbus_pkg::*;

  wstate_e           state_q;
  wstate_e           state_d;
  logic [ADDR_W-1:0] addr_hold_q;
  logic              pair_low;

  // Named events, visible to the assertions below
  logic start_evt;
  logic block_evt;
  logic finish_evt;
  logic abort_evt;
  logic release_evt;

  assign pair_low    = select_pair_low(cs_lvl, wr_lvl);
  assign start_evt   = (state_q == WS_IDLE)    &&  pair_low &&  oe_lvl;
  assign block_evt   = (state_q == WS_IDLE)    &&  pair_low && !oe_lvl;
  assign finish_evt  = (state_q == WS_ACTIVE)  && !pair_low;
  assign abort_evt   = (state_q == WS_ACTIVE)  &&  pair_low && !oe_lvl;
  assign release_evt = (state_q == WS_BLOCKED) && !pair_low;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      WS_IDLE: begin
        if (start_evt)      state_d = WS_ACTIVE;
        else if (block_evt) state_d = WS_BLOCKED;
      end
      WS_ACTIVE: begin
        if (finish_evt)     state_d = WS_IDLE;
        else if (abort_evt) state_d = WS_BLOCKED;
      end
      WS_BLOCKED: begin
        if (release_evt)    state_d = WS_IDLE;
      end
      default:              state_d = WS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= WS_IDLE;
      addr_hold_q <= '0;
      wr_valid    <= 1'b0;
      wr_addr     <= '0;
      wr_data     <= '0;
    end else begin
      state_q  <= state_d;
      wr_valid <= finish_evt;
      if (start_evt) begin
        addr_hold_q <= addr_in;
      end
      if (finish_evt) begin
        wr_addr <= addr_hold_q;
        wr_data <= data_in;
      end
    end
  end

  // R5: the strobe is never wider than one cycle
  assert_single_cycle_pulse_R5: assert property (
    @(posedge clk) disable iff (!rst_n)
    wr_valid |=> !wr_valid
  );

  // R5: a pulse follows only an open window
  assert_pulse_from_window_R5: assert property (
    @(posedge clk) disable iff (!rst_n)
    $rose(wr_valid) |-> ($past(state_q) == WS_ACTIVE)
  );

  // R6: an output-enable abort never produces a pulse
  assert_abort_is_silent_R6: assert property (
    @(posedge clk) disable iff (!rst_n)
    abort_evt |=> (!wr_valid && (state_q == WS_BLOCKED))
  );

  // R1: a start with output enable low is parked until the pair releases
  assert_blocked_start_R1: assert property (
    @(posedge clk) disable iff (!rst_n)
    block_evt |=> (state_q == WS_BLOCKED)
  );

  // R2: the held address does not move while a window stays open
  assert_addr_held_R2: assert property (
    @(posedge clk) disable iff (!rst_n)
    ((state_q == WS_ACTIVE) && ($past(state_q) == WS_ACTIVE)) |-> $stable(addr_hold_q)
  );

endmodule

// File: rtl/bus_write_capture.sv
`timescale 1ns/1ps
module bus_write_capture #(
  parameter int ADDR_W      = 20,
  parameter int DATA_W      = 16,
  parameter int SYNC_STAGES = 2,
  parameter int GLITCH_CYC  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_cs_n,
  input  logic              bus_wr_n,
  input  logic              bus_oe_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_data,
  output logic              wr_valid,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              rd_en,
  output logic              standby
);
  import wbus_pkg::*;

  localparam int BUS_W   = ADDR_W + DATA_W;
  localparam int BUS_DLY = capture_latency(SYNC_STAGES, GLITCH_CYC);

  logic [NUM_STROBES-1:0] strobe_raw;
  logic [NUM_STROBES-1:0] strobe_lvl;
  logic [BUS_W-1:0]       bus_now;
  logic [BUS_W-1:0]       bus_aligned;
  logic [ADDR_W-1:0]      addr_aligned;
  logic [DATA_W-1:0]      data_aligned;

  assign strobe_raw[STB_CS] = bus_cs_n;
  assign strobe_raw[STB_WR] = bus_wr_n;
  assign strobe_raw[STB_OE] = bus_oe_n;

  // One synchronizer and filter per strobe
  for (genvar g = 0; g < NUM_STROBES; g++) begin : g_strobe
    strobe_deglitch #(
      .SYNC_STAGES (SYNC_STAGES),
      .GLITCH_CYC  (GLITCH_CYC),
      .RST_LEVEL   (1'b1)
    ) u_deglitch (
      .clk   (clk),
      .rst_n (rst_n),
      .raw   (strobe_raw[g]),
      .level (strobe_lvl[g])
    );
  end

  // Buses delayed by exactly the strobe path so edges and values stay paired
  assign bus_now = {bus_addr, bus_data};

  bus_delay_line #(
    .WIDTH (BUS_W),
    .DEPTH (BUS_DLY)
  ) u_bus_dly (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (bus_now),
    .dout  (bus_aligned)
  );

  assign addr_aligned = bus_aligned[BUS_W-1 -: ADDR_W];
  assign data_aligned = bus_aligned[DATA_W-1:0];

  write_cycle_ctrl #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_lvl   (strobe_lvl[STB_CS]),
    .wr_lvl   (strobe_lvl[STB_WR]),
    .oe_lvl   (strobe_lvl[STB_OE]),
    .addr_in  (addr_aligned),
    .data_in  (data_aligned),
    .wr_valid (wr_valid),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data)
  );

  // Read-side decode from the filtered strobes
  assign rd_en   = read_window(strobe_lvl[STB_CS], strobe_lvl[STB_WR], strobe_lvl[STB_OE]);
  assign standby = strobe_lvl[STB_CS];

  // R8: a deselected chip never enables its outputs
  assert_standby_blocks_read_R8: assert property (
    @(posedge clk) disable iff (!rst_n)
    standby |-> !rd_en
  );

  // R9: no write leaves the block while reset is held
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      assert_reset_quiet_R9: assert (!wr_valid);
    end
  end

endmodule

// File: tb/bus_write_capture_tb.sv
`timescale 1ns/1ps
module bus_write_capture_tb;

  localparam int ADDR_W = 20;
  localparam int DATA_W = 16;
  localparam int SYNC_STAGES = 2;
  localparam int GLITCH_CYC = 3;
  localparam int LVL_LAT = SYNC_STAGES + GLITCH_CYC;   // 5
  localparam int WR_LAT  = SYNC_STAGES + GLITCH_CYC + 1; // 6
  localparam int QUIET   = 15;

  logic clk = 1'b0;
  logic rst_n = 1'b1;
  logic cs_n = 1'b1;
  logic wr_n = 1'b1;
  logic oe_n = 1'b1;
  logic [ADDR_W-1:0] addr = '0;
  logic [DATA_W-1:0] data = '0;
  logic wr_valid;
  logic [ADDR_W-1:0] wr_addr;
  logic [DATA_W-1:0] wr_data;
  logic rd_en;
  logic standby;

  int checks = 0;
  int failures = 0;
  int pulses = 0;
  logic [ADDR_W-1:0] last_addr = '0;
  logic [DATA_W-1:0] last_data = '0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  bus_write_capture #(
    .ADDR_W (ADDR_W), .DATA_W (DATA_W),
    .SYNC_STAGES (SYNC_STAGES), .GLITCH_CYC (GLITCH_CYC)
  ) u_dut (
    .clk (clk), .rst_n (rst_n),
    .bus_cs_n (cs_n), .bus_wr_n (wr_n), .bus_oe_n (oe_n),
    .bus_addr (addr), .bus_data (data),
    .wr_valid (wr_valid), .wr_addr (wr_addr), .wr_data (wr_data),
    .rd_en (rd_en), .standby (standby)
  );

  // Pulse monitor, sampled away from the active edge
  always @(negedge clk) begin
    if (rst_n && wr_valid) begin
      pulses    <= pulses + 1;
      last_addr <= wr_addr;
      last_data <= wr_data;
    end
  end

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic edges_until_valid(output int n);
    n = 0;
    for (int i = 1; i <= 20; i++) begin
      @(negedge clk);
      n = i;
      if (wr_valid) break;
    end
  endtask

  task automatic edges_until(input bit watch_rd, input logic want, output int n);
    n = 0;
    for (int i = 1; i <= 20; i++) begin
      @(negedge clk);
      n = i;
      if ((watch_rd ? rd_en : standby) === want) break;
    end
  endtask

  task automatic t_reset_state;
    cycles(2);
    check("R9", "standby after reset", {31'd0, standby}, 32'd1);
    check("R9", "rd_en after reset", {31'd0, rd_en}, 32'd0);
    check("R9", "wr_valid after reset", {31'd0, wr_valid}, 32'd0);
  endtask

  // Chip select first, write strobe closes the window
  task automatic t_write_cs_first;
    int n;
    int base;
    base = pulses;
    cs_n = 1'b0; addr = 20'h1A5A5;
    cycles(8);
    addr = 20'h0BEEF;
    cycles(3);
    wr_n = 1'b0; data = 16'h1111;
    cycles(8);
    addr = 20'h00077; data = 16'h2222;
    cycles(6);
    wr_n = 1'b1;
    @(negedge clk);
    data = 16'h3333;
    edges_until_valid(n);
    n = n + 1;
    check("R5", "write latency (write strobe end)", n, WR_LAT);
    check("R2", "address at later falling edge", wr_addr, 32'h0BEEF);
    check("R3", "data at write strobe rise", wr_data, 32'h2222);
    @(negedge clk);
    check("R5", "pulse one cycle wide", {31'd0, wr_valid}, 32'd0);
    cs_n = 1'b1;
    cycles(QUIET);
    check("R5", "one pulse per window", pulses - base, 1);
  endtask

  // Write strobe first, chip select closes the window
  task automatic t_write_wr_first;
    int n;
    int base;
    base = pulses;
    wr_n = 1'b0; addr = 20'h11111;
    cycles(8);
    addr = 20'h22222;
    cycles(2);
    cs_n = 1'b0; data = 16'hABCD;
    cycles(10);
    cs_n = 1'b1;
    @(negedge clk);
    data = 16'h0000;
    edges_until_valid(n);
    n = n + 1;
    check("R5", "write latency (chip select end)", n, WR_LAT);
    check("R2", "address at chip select fall", wr_addr, 32'h22222);
    check("R3", "data at chip select rise", wr_data, 32'hABCD);
    wr_n = 1'b1;
    cycles(QUIET);
    check("R5", "one pulse per window, reverse order", pulses - base, 1);
  endtask

  task automatic t_glitch_filter;
    int base;
    base = pulses;
    cs_n = 1'b0;
    cycles(10);
    wr_n = 1'b0; addr = 20'h00003; data = 16'h0005;
    cycles(GLITCH_CYC - 1);
    wr_n = 1'b1;
    cycles(QUIET);
    check("R4", "short write strobe pulse ignored", pulses - base, 0);
    wr_n = 1'b0;
    cycles(GLITCH_CYC);
    wr_n = 1'b1;
    cycles(QUIET);
    check("R4", "threshold-length pulse accepted", pulses - base, 1);
    check("R4", "threshold pulse address", last_addr, 32'h00003);
    check("R4", "threshold pulse data", last_data, 32'h0005);
    // short high glitch on the write strobe and a short low glitch on
    // output enable inside an open window must not end it
    wr_n = 1'b0; addr = 20'h00044; data = 16'h0066;
    cycles(10);
    wr_n = 1'b1;
    cycles(GLITCH_CYC - 1);
    wr_n = 1'b0;
    cycles(6);
    oe_n = 1'b0;
    cycles(GLITCH_CYC - 1);
    oe_n = 1'b1;
    cycles(8);
    data = 16'h0077;
    cycles(2);
    wr_n = 1'b1;
    cycles(QUIET);
    check("R4", "glitches inside window keep one write", pulses - base, 2);
    check("R4", "data from real end, not glitch", last_data, 32'h0077);
    cs_n = 1'b1;
    cycles(QUIET);
  endtask

  task automatic t_oe_rules;
    int base;
    base = pulses;
    cs_n = 1'b0; wr_n = 1'b0; addr = 20'h0AAAA; data = 16'h5555;
    cycles(10);
    oe_n = 1'b0;
    cycles(10);
    cs_n = 1'b1; wr_n = 1'b1;
    cycles(3);
    oe_n = 1'b1;
    cycles(QUIET);
    check("R6", "output enable abort gives no write", pulses - base, 0);
    oe_n = 1'b0;
    cycles(8);
    cs_n = 1'b0; wr_n = 1'b0;
    cycles(10);
    check("R7", "rd_en low while write strobe low", {31'd0, rd_en}, 32'd0);
    oe_n = 1'b1;
    cycles(10);
    cs_n = 1'b1; wr_n = 1'b1;
    cycles(QUIET);
    check("R1", "start with output enable low blocked", pulses - base, 0);
  endtask

  task automatic t_read_decode;
    int n;
    check("R8", "standby while deselected", {31'd0, standby}, 32'd1);
    cs_n = 1'b0; oe_n = 1'b0;
    edges_until(1'b1, 1'b1, n);
    check("R7", "rd_en latency", n, LVL_LAT);
    check("R8", "standby low while selected", {31'd0, standby}, 32'd0);
    cs_n = 1'b1;
    edges_until(1'b0, 1'b1, n);
    check("R8", "standby latency", n, LVL_LAT);
    check("R8", "rd_en low in standby", {31'd0, rd_en}, 32'd0);
    oe_n = 1'b1;
    cycles(10);
  endtask

  task automatic t_reset_midcycle;
    int base;
    base = pulses;
    cs_n = 1'b0; wr_n = 1'b0; addr = 20'h0F00F; data = 16'h9999;
    cycles(10);
    rst_n = 1'b0;
    @(negedge clk);
    check("R9", "wr_valid low in reset", {31'd0, wr_valid}, 32'd0);
    cs_n = 1'b1; wr_n = 1'b1;
    cycles(8);
    rst_n = 1'b1;
    cycles(QUIET);
    check("R9", "partial cycle dropped by reset", pulses - base, 0);
    check("R9", "standby after mid-cycle reset", {31'd0, standby}, 32'd1);
  endtask

  initial begin
    #1 rst_n = 1'b0;
    cycles(4);
    rst_n = 1'b1;
    t_reset_state();
    t_write_cs_first();
    t_write_wr_first();
    t_glitch_filter();
    t_oe_rules();
    t_read_decode();
    t_reset_midcycle();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule